// File: doc/BRIEF.md
# Processor Status and Condition Flag Register

This block holds the 16-bit processor status word. It has the four arithmetic condition flags (carry, zero, negative, signed overflow), the global enable for maskable interrupts, and four power-control bits. The execute stage reports each add, subtract or compare result at one of three operand widths: 8-bit byte, 16-bit word and 20-bit address. The block then works out the new condition flags from the operand and result sign bits and from the carry bit of the result.

Move, bit-set and bit-clear instructions write the register directly: a plain load, an OR mask, or an AND-NOT mask. The block accepts these writes only in word register mode. A 20-bit-wide write never changes the register.

The register drives the individual flags and gates a vector of maskable interrupt requests with the enable bit. It also raises a low-power request whenever any of the four power bits is set.

Top module: `status_flag_reg`

## Requirements
- R1: While rst_ni is low the register is all zeros, and so are every flag output, lpm_req_o and irq_o.
- R2: The bit layout is carry 0, zero 1, negative 2, interrupt enable 3, cpu-off 4, oscillator-off 5, clock-gen-0 6, clock-gen-1 7 and overflow 8. Bits 15 to 9 always read 0 and ignore writes.
- R3: flag_width_i selects the operand width: 0 is 8 bits, 1 is 16 bits, 2 is 20 bits, and 3 acts as 16 bits. Operand and result bits above the selected width have no effect on the flags.
- R4: On a flag update, N takes the result bit at width-1, and Z is 1 exactly when the low width bits of the result are all 0.
- R5: On a flag update, C takes the result bit at position width, one above the operand width.
- R6: When flag_sub_i=0 (add), V is 1 exactly when both operands have the same sign and the result sign differs from it.
- R7: When flag_sub_i=1 (subtract or compare, result = dst minus src), V is 1 exactly when the operand signs differ and the result sign differs from the dst sign.
- R8: A flag update changes only C, Z, N and V. Bits 3 to 7 keep their value.
- R9: An accepted write with wr_mode_i=0 loads wr_data_i, with the reserved bits forced to 0.
- R10: wr_mode_i=1 ORs wr_data_i into the register. wr_mode_i=2 clears each bit set in wr_data_i. wr_mode_i=3 leaves the register unchanged.
- R11: A write with wr_wide_i=1 leaves the register unchanged.
- R12: If an accepted write and a flag update arrive in the same cycle, the write wins and the flags from the update are dropped. A write ignored under R10 or R11 does not block a flag update in the same cycle.
- R13: irq_o equals irq_i when the enable bit is 1 and is all zeros when it is 0.
- R14: cpu_off_o mirrors bit 4, and lpm_req_o is 1 exactly when any of bits 4 to 7 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flag_en_i | input | 1 | Apply an ALU flag update this cycle |
| flag_sub_i | input | 1 | 1 for subtract/compare, 0 for add |
| flag_width_i | input | 2 | Operand width select |
| src_i | input | 20 | Source operand |
| dst_i | input | 20 | Destination operand |
| res_i | input | 21 | ALU result including the bit above the width |
| wr_en_i | input | 1 | Register write request |
| wr_wide_i | input | 1 | Write is 20-bit wide (ignored) |
| wr_mode_i | input | 2 | 0 load, 1 OR mask, 2 AND-NOT mask, 3 none |
| wr_data_i | input | 16 | Write value or mask |
| irq_i | input | NUM_IRQ | Maskable interrupt requests |
| sr_o | output | 16 | Register contents |
| c_o | output | 1 | Carry flag |
| z_o | output | 1 | Zero flag |
| n_o | output | 1 | Negative flag |
| v_o | output | 1 | Overflow flag |
| gie_o | output | 1 | Maskable interrupt enable |
| cpu_off_o | output | 1 | CPU-off request |
| lpm_req_o | output | 1 | Any low-power bit set |
| irq_o | output | NUM_IRQ | Interrupt requests after gating |

## Verification
Every output is a combinational function of the one state register. A wrong stored bit therefore shows up at sr_o and the matching flag, enable or power output in the cycle right after the faulty update. There is no delay that could hide it. Each operation is therefore compared against a reference model in the following cycle. Width selection errors show up as the wrong sign or carry bit at byte and address boundaries. Priority errors show up as flags leaking over a simultaneous write.

// File: rtl/sr_pkg.sv
package sr_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;
  localparam int ADDR_W = 20;
  localparam int SR_W   = 16;

  localparam int C_BIT    = 0;
  localparam int Z_BIT    = 1;
  localparam int N_BIT    = 2;
  localparam int GIE_BIT  = 3;
  localparam int CPUOFF_BIT = 4;
  localparam int PWR_LO   = 4;
  localparam int PWR_HI   = 7;
  localparam int V_BIT    = 8;

  localparam logic [SR_W-1:0] IMPL_MASK = 16'h01FF;

  typedef enum logic [1:0] {
    WID_BYTE = 2'd0,
    WID_WORD = 2'd1,
    WID_ADDR = 2'd2,
    WID_ALT  = 2'd3
  } width_e;

  typedef enum logic [1:0] {
    WR_LOAD = 2'd0,
    WR_SET  = 2'd1,
    WR_CLR  = 2'd2,
    WR_NONE = 2'd3
  } wr_mode_e;

  typedef struct packed {
    logic v;
    logic n;
    logic z;
    logic c;
  } flags_t;
endpackage

// File: rtl/sr_flag_calc.sv
module sr_flag_calc
  import sr_pkg::*;
#(
  parameter int B_W = BYTE_W,
  parameter int W_W = WORD_W,
  parameter int A_W = ADDR_W
) (
  input  logic [1:0]   width_i,
  input  logic         sub_i,
  input  logic [A_W-1:0] src_i,
  input  logic [A_W-1:0] dst_i,
  input  logic [A_W:0]   res_i,
  output flags_t       flags_o
);
  localparam int NW = 3;

  logic [3:0] per_w [NW];
  logic unused_ops;
  assign unused_ops = ^{src_i, dst_i};

  for (genvar g = 0; g < NW; g++) begin : g_w
    localparam int W = (g == 0) ? B_W : (g == 1) ? W_W : A_W;
    logic s_sgn, d_sgn, r_sgn, ovf;
    assign s_sgn = src_i[W-1];
    assign d_sgn = dst_i[W-1];
    assign r_sgn = res_i[W-1];
    // subtract: dst - src
    assign ovf = sub_i ? ((d_sgn != s_sgn) && (r_sgn != d_sgn))
                       : ((d_sgn == s_sgn) && (r_sgn != s_sgn));
    assign per_w[g] = {ovf, r_sgn, ~|res_i[W-1:0], res_i[W]};
  end

  always_comb begin
    case (width_i)
      WID_BYTE: flags_o = per_w[0];
      WID_ADDR: flags_o = per_w[2];
      default:  flags_o = per_w[1];
    endcase
  end
endmodule

// File: rtl/sr_write_merge.sv
module sr_write_merge
  import sr_pkg::*;
#(
  parameter int W = SR_W
) (
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] data_i,
  input  logic [1:0]   mode_i,
  output logic [W-1:0] next_o
);
  logic [W-1:0] raw;

  always_comb begin
    case (mode_i)
      WR_LOAD: raw = data_i;
      WR_SET:  raw = cur_i | data_i;
      WR_CLR:  raw = cur_i & ~data_i;
      default: raw = cur_i;
    endcase
    next_o = raw & IMPL_MASK[W-1:0];
  end
endmodule

// File: rtl/sr_ctrl_out.sv
module sr_ctrl_out
  import sr_pkg::*;
#(
  parameter int NUM_IRQ = 8
) (
  input  logic [SR_W-1:0]    sr_i,
  input  logic [NUM_IRQ-1:0] irq_i,
  output logic               lpm_req_o,
  output logic [NUM_IRQ-1:0] irq_o
);
  assign lpm_req_o = |sr_i[PWR_HI:PWR_LO];
  assign irq_o     = irq_i & {NUM_IRQ{sr_i[GIE_BIT]}};
endmodule

// File: rtl/status_flag_reg.sv
module status_flag_reg
  import sr_pkg::*;
#(
  parameter int NUM_IRQ = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 flag_en_i,
  input  logic                 flag_sub_i,
  input  logic [1:0]           flag_width_i,
  input  logic [ADDR_W-1:0]    src_i,
  input  logic [ADDR_W-1:0]    dst_i,
  input  logic [ADDR_W:0]      res_i,
  input  logic                 wr_en_i,
  input  logic                 wr_wide_i,
  input  logic [1:0]           wr_mode_i,
  input  logic [SR_W-1:0]      wr_data_i,
  input  logic [NUM_IRQ-1:0]   irq_i,
  output logic [SR_W-1:0]      sr_o,
  output logic                 c_o,
  output logic                 z_o,
  output logic                 n_o,
  output logic                 v_o,
  output logic                 gie_o,
  output logic                 cpu_off_o,
  output logic                 lpm_req_o,
  output logic [NUM_IRQ-1:0]   irq_o
);
  logic [SR_W-1:0] sr_q, wr_next;
  flags_t          alu_f;
  logic            wr_take;

  sr_flag_calc #(.B_W(BYTE_W), .W_W(WORD_W), .A_W(ADDR_W)) u_calc (
    .width_i (flag_width_i),
    .sub_i   (flag_sub_i),
    .src_i   (src_i),
    .dst_i   (dst_i),
    .res_i   (res_i),
    .flags_o (alu_f)
  );

  sr_write_merge #(.W(SR_W)) u_merge (
    .cur_i  (sr_q),
    .data_i (wr_data_i),
    .mode_i (wr_mode_i),
    .next_o (wr_next)
  );

  sr_ctrl_out #(.NUM_IRQ(NUM_IRQ)) u_ctrl (
    .sr_i      (sr_q),
    .irq_i     (irq_i),
    .lpm_req_o (lpm_req_o),
    .irq_o     (irq_o)
  );

  // only word-mode writes with a real mode count
  assign wr_take = wr_en_i && !wr_wide_i && (wr_mode_i != WR_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
    end else if (wr_take) begin
      sr_q <= wr_next;
    end else if (flag_en_i) begin
      sr_q[C_BIT] <= alu_f.c;
      sr_q[Z_BIT] <= alu_f.z;
      sr_q[N_BIT] <= alu_f.n;
      sr_q[V_BIT] <= alu_f.v;
    end
  end

  assign sr_o      = sr_q;
  assign c_o       = sr_q[C_BIT];
  assign z_o       = sr_q[Z_BIT];
  assign n_o       = sr_q[N_BIT];
  assign v_o       = sr_q[V_BIT];
  assign gie_o     = sr_q[GIE_BIT];
  assign cpu_off_o = sr_q[CPUOFF_BIT];

  assert_flag_scope_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_en_i && !wr_take) |=> (sr_q[PWR_HI:GIE_BIT] == $past(sr_q[PWR_HI:GIE_BIT])));

  assert_set_mask_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_take && wr_mode_i == WR_SET) |=>
      ((sr_q & $past(wr_data_i & IMPL_MASK)) == $past(wr_data_i & IMPL_MASK)));

  assert_clr_mask_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_take && wr_mode_i == WR_CLR) |=> ((sr_q & $past(wr_data_i)) == '0));

  assert_wide_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_wide_i && !flag_en_i) |=> $stable(sr_q));

  assert_irq_block_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_o |-> (irq_o == '0));

  assert_cpuoff_lpm_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_off_o |-> lpm_req_o);
endmodule

// File: tb/status_flag_reg_bench.sv
`timescale 1ns/1ps
module status_flag_reg_bench;
  localparam int NI = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic flag_en_i = 1'b0, flag_sub_i = 1'b0, wr_en_i = 1'b0, wr_wide_i = 1'b0;
  logic [1:0] flag_width_i = 2'd0, wr_mode_i = 2'd0;
  logic [19:0] src_i = '0, dst_i = '0;
  logic [20:0] res_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [NI-1:0] irq_i = '0;
  logic [15:0] sr_o;
  logic c_o, z_o, n_o, v_o, gie_o, cpu_off_o, lpm_req_o;
  logic [NI-1:0] irq_o;

  always #2 clk = ~clk;

  status_flag_reg #(.NUM_IRQ(NI)) u_status_flag_reg (
    .clk_i(clk), .rst_ni(rst_ni), .flag_en_i(flag_en_i), .flag_sub_i(flag_sub_i),
    .flag_width_i(flag_width_i), .src_i(src_i), .dst_i(dst_i), .res_i(res_i),
    .wr_en_i(wr_en_i), .wr_wide_i(wr_wide_i), .wr_mode_i(wr_mode_i),
    .wr_data_i(wr_data_i), .irq_i(irq_i), .sr_o(sr_o), .c_o(c_o), .z_o(z_o),
    .n_o(n_o), .v_o(v_o), .gie_o(gie_o), .cpu_off_o(cpu_off_o),
    .lpm_req_o(lpm_req_o), .irq_o(irq_o)
  );

  typedef struct {
    logic [15:0]   sr;
    logic [NI-1:0] irq;
    string         tag;
  } exp_t;

  exp_t exp_q[$];
  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] model = '0;

  task automatic compare(input exp_t e);
    logic [20:0] act, want;
    act  = {sr_o, c_o, z_o, n_o, v_o, gie_o};
    want = {e.sr, e.sr[0], e.sr[1], e.sr[2], e.sr[8], e.sr[3]};
    n_cmp++;
    if (act !== want || irq_o !== e.irq || cpu_off_o !== e.sr[4] ||
        lpm_req_o !== (|e.sr[7:4])) begin
      n_bad++;
      $display("FAIL %s: sr=%h irq=%h lpm=%b cpu=%b expected sr=%h irq=%h lpm=%b cpu=%b",
               e.tag, sr_o, irq_o, lpm_req_o, cpu_off_o, e.sr, e.irq, |e.sr[7:4], e.sr[4]);
    end
  endtask

  task automatic drive(input bit fen, input bit fsub, input logic [1:0] fw,
                       input logic [19:0] s, input logic [19:0] d,
                       input bit wen, input bit wwide, input logic [1:0] wm,
                       input logic [15:0] wd, input logic [NI-1:0] irq,
                       input string tag);
    int w;
    longint mask, us, ud, ss, sd, res, sum, lim;
    exp_t e;
    @(negedge clk);
    w    = (fw == 2'd0) ? 8 : (fw == 2'd2) ? 20 : 16;
    mask = (longint'(1) << w) - 1;
    lim  = longint'(1) << (w - 1);
    us   = longint'(s) & mask;
    ud   = longint'(d) & mask;
    res  = fsub ? (ud + ((~us) & mask) + 1) : (ud + us);
    ss   = (us >= lim) ? us - (longint'(1) << w) : us;
    sd   = (ud >= lim) ? ud - (longint'(1) << w) : ud;
    sum  = fsub ? sd - ss : sd + ss;
    flag_en_i = fen; flag_sub_i = fsub; flag_width_i = fw;
    src_i = s; dst_i = d; res_i = res[20:0];
    wr_en_i = wen; wr_wide_i = wwide; wr_mode_i = wm; wr_data_i = wd; irq_i = irq;
    if (wen && !wwide && wm != 2'd3) begin
      case (wm)
        2'd0: model = wd;
        2'd1: model = model | wd;
        default: model = model & ~wd;
      endcase
      model &= 16'h01FF;
    end else if (fen) begin
      model[0] = res[w];
      model[1] = ((res & mask) == 0);
      model[2] = res[w-1];
      model[8] = (sum >= lim) || (sum < -lim);
    end
    e.sr  = model;
    e.irq = irq & {NI{model[3]}};
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) compare(exp_q.pop_front());
    end
  end

  initial begin : watchdog
    #(200000 * 4);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stim
    exp_t r;
    repeat (3) @(negedge clk);
    r.sr = '0; r.irq = '0; r.tag = "R1 reset state";
    irq_i = 8'hFF;
    #0.5 compare(r);
    irq_i = '0;
    @(negedge clk); rst_ni = 1'b1;

    // R9 R2 R13 R14: full load, reserved dropped
    drive(0,0,0, 0,0, 1,0,2'd0, 16'hFFFF, 8'hA5, "R9 R2 R13 R14 load all ones");
    drive(0,0,0, 0,0, 1,0,2'd2, 16'h00F0, 8'h3C, "R10 R14 clear power bits");
    drive(0,0,0, 0,0, 1,0,2'd2, 16'h0008, 8'hFF, "R13 clear enable blocks irq");
    drive(0,0,0, 0,0, 1,0,2'd1, 16'hFE30, 8'h0F, "R10 R2 R14 set cpu and osc off");
    drive(0,0,0, 0,0, 1,0,2'd3, 16'hFFFF, 8'h00, "R10 mode 3 no effect");
    drive(0,0,0, 0,0, 1,1,2'd0, 16'h0000, 8'h00, "R11 wide write ignored");
    drive(0,0,0, 0,0, 1,0,2'd0, 16'h0008, 8'h00, "R9 load enable only");
    // flag updates
    drive(1,0,2'd0, 20'h00001, 20'h0007F, 0,0,0,0, 8'h81, "R3 R4 R6 byte add overflow");
    drive(1,0,2'd0, 20'h12301, 20'hABCFF, 0,0,0,0, 8'h81, "R3 R4 R5 byte add wrap zero carry");
    drive(1,0,2'd1, 20'h08000, 20'h08000, 0,0,0,0, 8'h00, "R5 R6 word add neg overflow");
    drive(1,1,2'd1, 20'h0FFFF, 20'h07FFF, 0,0,0,0, 8'h00, "R7 word sub pos minus neg");
    drive(1,1,2'd1, 20'h00001, 20'h08000, 0,0,0,0, 8'h00, "R7 R5 word sub neg minus pos");
    drive(1,0,2'd2, 20'h00001, 20'h7FFFF, 0,0,0,0, 8'h00, "R3 R6 addr add overflow");
    drive(1,1,2'd2, 20'h00005, 20'h00005, 0,0,0,0, 8'h00, "R4 R5 R7 addr compare equal");
    drive(1,0,2'd3, 20'h00001, 20'h07FFF, 0,0,0,0, 8'h00, "R3 width code 3 as word");
    drive(1,1,2'd0, 20'h00080, 20'h00001, 0,0,0,0, 8'h00, "R7 byte sub pos minus neg");
    // R8: power and enable bits survive a flag update
    drive(0,0,0, 0,0, 1,0,2'd1, 16'h00F8, 8'h00, "R10 set upper control bits");
    drive(1,0,2'd1, 20'h00000, 20'h00000, 0,0,0,0, 8'h55, "R8 flag update keeps control bits");
    // R12 priority
    drive(1,0,2'd1, 20'h08000, 20'h08000, 1,0,2'd0, 16'h0008, 8'hF0, "R12 write beats flags");
    drive(1,0,2'd1, 20'h08000, 20'h08000, 1,1,2'd0, 16'h0000, 8'hF0, "R12 R11 ignored write lets flags in");
    drive(1,0,2'd0, 20'h00040, 20'h00040, 1,0,2'd3, 16'h0000, 8'h0F, "R12 R10 mode 3 lets flags in");
    drive(0,0,0, 0,0, 0,0,0,0, 8'h00, "R1 idle holds");
    drive(0,0,0, 0,0, 0,0,0,0, 8'h00, "R1 idle holds");
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule